// File: doc/BRIEF.md
# Incremental PI Regulator with Output Clamp

This block is a fixed-point proportional-integral regulator in incremental (velocity) form. It serves the inner current loop and the outer voltage loop of a power-factor-correction stage alike. Each accepted error sample is a signed Q15 word. The block forms a correction from the change in error and from the error itself, adds it to the output it produced last time, and presents the result as a new Q15 word. The proportional and integral gains are Q15 inputs. The integral gain already folds in the ratio of sample period to integral time, and the block applies it as given.

The two gain products are formed at full Q30 precision and summed in a wide accumulator. The sum is rounded back to Q15 and added to the stored previous output. That total is saturated to the 16-bit signed range and then limited to a window set by two signed bound inputs. The stored previous output is the limited value, so the regulator never winds up beyond its window.

Samples enter on a valid/ready stream and results leave on a second valid/ready stream. The output holds one result. A new sample is accepted only when that holding place is empty or is being drained in the same cycle, so back-pressure on the output stalls the input. A synchronous clear drops any pending result and zeroes the regulator history.

Top module: `pi_velocity_reg`

## Requirements
- R1: After reset `res_valid` is 0, `err_ready` is 1, and the stored previous error and previous output are both 0.
- R2: For an accepted error e, with stored previous error ep and previous output vp, the block computes acc = kp·(e−ep) + ki·e in Q30. It then forms inc = floor((acc + 2^14) / 2^15), which rounds half toward +infinity, and s = inc + vp.
- R3: Each accepted sample becomes the stored previous error for the next sample, so the proportional term acts on the difference between consecutive samples.
- R4: s is saturated to [−32768, 32767] before the window limit is applied.
- R5: The saturated value is first lowered to `lim_hi` if it is above it, and then raised to `lim_lo` if it is below it. When `lim_lo` > `lim_hi` the result is therefore `lim_lo`.
- R6: The stored previous output is the limited result. After the output has been pinned at a bound, a correction in the opposite direction moves it off the bound at once.
- R7: `err_ready` is high exactly when no result is pending or `res_ready` is high. A sample is accepted on a rising edge with `err_valid` and `err_ready` both high and `clr` low, and its result is shown with `res_valid` high after that edge.
- R8: While `res_valid` is high and `res_ready` is low, `res_data` and `res_valid` stay unchanged. Samples offered during the stall are not taken and leave the history unchanged.
- R9: With `clr` high at an edge, `res_valid` goes low, the history becomes zero, and any sample offered in that cycle is discarded.
- R10: Gains and limits are sampled in the cycle a sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of history and pending result |
| kp | input | 16 | Proportional gain, signed Q15 |
| ki | input | 16 | Integral gain, signed Q15 |
| lim_lo | input | 16 | Lower output bound, signed Q15 |
| lim_hi | input | 16 | Upper output bound, signed Q15 |
| err_valid | input | 1 | Error sample valid |
| err_ready | output | 1 | Block can take an error sample |
| err_data | input | 16 | Error sample, signed Q15 |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 16 | Regulator output, signed Q15 |

## Verification
The bench builds the block with its defaults: a 16-bit data path with 15 fraction bits, which gives a 34-bit accumulator. At this width, full-scale gains with a full-scale error swing drive the Q30 sum far past the Q15 range. That reaches the saturation stage ahead of the window limit. Unit-gain tests on the integral path alone place the accumulator exactly on a rounding half step for both signs, so the rounding rule is checked directly.

// File: rtl/pi_pkg.sv
package pi_pkg;
  localparam int unsigned PI_DATA_W = 16;
  localparam int unsigned PI_FRAC_W = 15;

  function automatic int unsigned pi_acc_w(input int unsigned dw);
    return 2 * dw + 2;
  endfunction
endpackage

// File: rtl/pi_incr_term.sv
module pi_incr_term #(
  parameter int unsigned DW    = 16,
  parameter int unsigned FRAC  = 15,
  parameter int unsigned ACC_W = 2 * DW + 2,
  parameter int unsigned INC_W = ACC_W - FRAC
) (
  input  logic signed [DW-1:0]    kp,
  input  logic signed [DW-1:0]    ki,
  input  logic signed [DW-1:0]    e_now,
  input  logic signed [DW-1:0]    e_old,
  output logic signed [INC_W-1:0] inc
);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);

  logic signed [ACC_W-1:0] kp_x, ki_x, en_x, eo_x, diff_x;
  logic signed [ACC_W-1:0] p_prop, p_int, acc;

  always_comb begin
    kp_x   = ACC_W'(kp);
    ki_x   = ACC_W'(ki);
    en_x   = ACC_W'(e_now);
    eo_x   = ACC_W'(e_old);
    diff_x = en_x - eo_x;
    p_prop = kp_x * diff_x;
    p_int  = ki_x * en_x;
    acc    = p_prop + p_int + HALF;
    inc    = acc[ACC_W-1:FRAC];
  end
endmodule

// File: rtl/pi_sat_clamp.sv
module pi_sat_clamp #(
  parameter int unsigned DW   = 16,
  parameter int unsigned IN_W = 20
) (
  input  logic signed [IN_W-1:0] sum,
  input  logic signed [DW-1:0]   lo,
  input  logic signed [DW-1:0]   hi,
  output logic signed [DW-1:0]   y
);
  localparam logic signed [DW-1:0] MAX_D = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MIN_D = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [IN_W-1:0] MAX_W = IN_W'(MAX_D);
  localparam logic signed [IN_W-1:0] MIN_W = IN_W'(MIN_D);

  logic signed [DW-1:0] sat;

  always_comb begin
    if (sum > MAX_W)      sat = MAX_D;
    else if (sum < MIN_W) sat = MIN_D;
    else                  sat = sum[DW-1:0];
    y = sat;
    if (y > hi) y = hi;
    if (y < lo) y = lo;
  end
endmodule

// File: rtl/pi_velocity_reg.sv
module pi_velocity_reg #(
  parameter int unsigned DW   = pi_pkg::PI_DATA_W,
  parameter int unsigned FRAC = pi_pkg::PI_FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [DW-1:0] kp,
  input  logic [DW-1:0] ki,
  input  logic [DW-1:0] lim_lo,
  input  logic [DW-1:0] lim_hi,
  input  logic          err_valid,
  output logic          err_ready,
  input  logic [DW-1:0] err_data,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data
);
  localparam int unsigned ACC_W = pi_pkg::pi_acc_w(DW);
  localparam int unsigned INC_W = ACC_W - FRAC;
  localparam int unsigned SUM_W = INC_W + 1;

  logic signed [DW-1:0]    e_prev, v_prev, v_next;
  logic signed [INC_W-1:0] inc;
  logic signed [SUM_W-1:0] sum;
  logic                    take;

  assign err_ready = !res_valid || res_ready;
  assign take      = err_valid && err_ready && !clr;

  pi_incr_term #(.DW(DW), .FRAC(FRAC), .ACC_W(ACC_W), .INC_W(INC_W)) u_term (
    .kp    (signed'(kp)),
    .ki    (signed'(ki)),
    .e_now (signed'(err_data)),
    .e_old (e_prev),
    .inc   (inc)
  );

  assign sum = SUM_W'(inc) + SUM_W'(v_prev);

  pi_sat_clamp #(.DW(DW), .IN_W(SUM_W)) u_clamp (
    .sum (sum),
    .lo  (signed'(lim_lo)),
    .hi  (signed'(lim_hi)),
    .y   (v_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_prev    <= '0;
      v_prev    <= '0;
      res_valid <= 1'b0;
    end else if (clr) begin
      e_prev    <= '0;
      v_prev    <= '0;
      res_valid <= 1'b0;
    end else if (take) begin
      e_prev    <= signed'(err_data);
      v_prev    <= v_next;
      res_valid <= 1'b1;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assign res_data = v_prev;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !clr) |=> (res_valid && $stable(res_data))); // R8

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!res_valid && res_data == '0)); // R9

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_ready && !clr) |=> res_valid); // R7

  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !err_ready); // R7

  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (take && signed'(lim_lo) <= signed'(lim_hi)) |=>
      (signed'(res_data) >= $past(signed'(lim_lo)) &&
       signed'(res_data) <= $past(signed'(lim_hi)))); // R5
endmodule

// File: tb/pi_velocity_reg_test.sv
module pi_velocity_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [15:0] kp = '0, ki = '0, lim_lo = 16'h8000, lim_hi = 16'h7fff;
  logic        err_valid = 1'b0;
  logic        err_ready;
  logic [15:0] err_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [15:0] res_data;

  int n_checks = 0;
  int n_fail   = 0;
  longint m_ep = 0, m_vp = 0;

  always #4 clk = ~clk;

  pi_velocity_reg uut (
    .clk, .rst_n, .clr, .kp, .ki, .lim_lo, .lim_hi,
    .err_valid, .err_ready, .err_data,
    .res_valid, .res_ready, .res_data
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint model(input longint e);
    longint acc, inc, s, lo, hi;
    acc = longint'($signed(kp)) * (e - m_ep) + longint'($signed(ki)) * e;
    inc = (acc + 16384) >>> 15;
    s   = inc + m_vp;
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    lo = longint'($signed(lim_lo));
    hi = longint'($signed(lim_hi));
    if (s > hi) s = hi;
    if (s < lo) s = lo;
    m_ep = e;
    m_vp = s;
    return s;
  endfunction

  task automatic set_cfg(input int p, input int i, input int lo, input int hi);
    kp = 16'(p); ki = 16'(i); lim_lo = 16'(lo); lim_hi = 16'(hi);
  endtask

  task automatic send(input string req, input int e);
    longint exp;
    @(negedge clk);
    err_valid = 1'b1;
    err_data  = 16'(e);
    exp = model(e);
    @(negedge clk);
    err_valid = 1'b0;
    check({req, " valid"}, res_valid, 1);
    check({req, " data"}, longint'($signed(res_data)), exp);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    m_ep = 0; m_vp = 0;
  endtask

  task automatic t_reset();
    check("R1 res_valid", res_valid, 0);
    check("R1 err_ready", err_ready, 1);
    set_cfg(0, 32767, -32768, 32767);
    send("R1 first", 100);
  endtask

  task automatic t_rounding();
    do_clear();
    set_cfg(0, 1, -32768, 32767);
    send("R2 +half", 16384);
    send("R2 below", 16383);
    send("R2 -half", -16384);
    send("R2 -over", -16385);
  endtask

  task automatic t_law();
    do_clear();
    set_cfg(16384, 3277, -32768, 32767);
    send("R2 step1", 1000);
    send("R3 step2", 1000);
    send("R3 step3", -2500);
    send("R3 step4", 7000);
  endtask

  task automatic t_saturate();
    do_clear();
    set_cfg(32767, 32767, -32768, 32767);
    send("R4 low", -32768);
    send("R4 high", 32767);
    send("R4 high again", 32767);
    send("R4 swing", -32768);
  endtask

  task automatic t_clamp();
    do_clear();
    set_cfg(16384, 16384, -1000, 2000);
    send("R5 up", 8000);
    send("R6 pinned", 8000);
    send("R6 back off", -3000);
    send("R5 down", -20000);
    set_cfg(16384, 16384, 500, 100);
    send("R5 lo>hi", 50);
  endtask

  task automatic t_stall();
    longint exp;
    do_clear();
    set_cfg(16384, 3277, -32768, 32767);
    res_ready = 1'b0;
    send("R8 first", 4000);
    exp = m_vp;
    @(negedge clk);
    err_valid = 1'b1;
    err_data  = 16'(-6000);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8 ready low", err_ready, 0);
      check("R8 held", longint'($signed(res_data)), exp);
      check("R8 still valid", res_valid, 1);
    end
    res_ready = 1'b1;
    exp = model(-6000);
    @(negedge clk);
    err_valid = 1'b0;
    check("R8 resumed data", longint'($signed(res_data)), exp);
    check("R7 resumed valid", res_valid, 1);
    @(negedge clk);
    check("R7 drained", res_valid, 0);
  endtask

  task automatic t_clear();
    set_cfg(16384, 3277, -32768, 32767);
    send("R9 before", 9000);
    @(negedge clk);
    clr = 1'b1;
    err_valid = 1'b1;
    err_data = 16'(12000);
    @(negedge clk);
    clr = 1'b0;
    err_valid = 1'b0;
    m_ep = 0; m_vp = 0;
    check("R9 valid dropped", res_valid, 0);
    check("R9 data zero", longint'($signed(res_data)), 0);
    send("R9 after", 3000);
  endtask

  task automatic t_cfg_sample();
    do_clear();
    set_cfg(8192, 1000, -32768, 32767);
    send("R10 cfg A", 5000);
    set_cfg(-8192, 20000, -32768, 32767);
    send("R10 cfg B", 5000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rounding();
        t_law();
        t_saturate();
        t_clamp();
        t_stall();
        t_clear();
        t_cfg_sample();
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule